// File: doc/BRIEF.md
# Nested System-Management Interrupt Entry Controller

This block decides when a system-management interrupt (SMI) is taken, and it tracks how deeply those interrupts are nested. It holds two architectural bits. The first is a nest-enable bit, which software sets to allow a further SMI while one is already being serviced. The second is a nested-status bit, which is 1 whenever the current level was entered from inside management mode or from a deeper level. Two request lines, one internal and one external, are arbitrated every cycle. An external request that cannot be accepted yet is latched and served later.

Each accepted SMI pushes the previous nested-status value onto a small save stack and increments a depth counter. A resume strobe pops the saved value back and decrements the depth counter. Software reaches the nest-enable bit through a one-bit write port. All outputs are registered, so every decision taken on the inputs of one clock edge becomes visible right after that edge.

Top module: `smi_nest_ctrl`

## Requirements
- R1: After synchronous reset, and at any time the depth is 0, nest-enable reads 1, nested-status reads 0, depth reads 0 and in-mode reads 0.
- R2: Taking an SMI produces a one-cycle take pulse. The same edge clears nest-enable, sets nested-status to 1, increments the depth and saves the old nested-status value.
- R3: An external SMI that would be accepted while the depth already equals SAVE_DEPTH is dropped. It raises a one-cycle overflow pulse, leaves depth and both bits unchanged, and clears the pending flag.
- R4: An external request seen while the depth is non-zero and nest-enable is 0 sets the pending flag and is not taken. The flag is taken as an external SMI on the first edge at which it becomes acceptable.
- R5: With the depth non-zero and nest-enable at 1, an external request (new or pending) is taken as a deeper level.
- R6: An internal request while the depth is non-zero is ignored: it is never taken and never latched.
- R7: At depth 0, simultaneous internal and external requests take the internal one (source code 0). The external one becomes pending. A lone external take reports source code 1.
- R8: A resume strobe at non-zero depth sets nest-enable to 1, restores nested-status from the value saved for that level, and decrements the depth. In that cycle it wins over any take; an external request in the same cycle becomes pending.
- R9: A software write sets nest-enable to the written bit only while the depth is non-zero and no take or resume happens in that cycle. A write at depth 0 has no effect.
- R10: A resume strobe at depth 0 changes no state and raises a one-cycle protocol-error pulse.
- R11: The in-mode output is 1 exactly when the depth is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_req_i | input | 1 | Internal SMI request |
| ext_req_i | input | 1 | External SMI request |
| rsm_i | input | 1 | Resume strobe |
| cfg_we_i | input | 1 | Write strobe for nest-enable |
| cfg_wdata_i | input | 1 | Value written to nest-enable |
| nest_en_o | output | 1 | Nest-enable bit |
| nest_stat_o | output | 1 | Nested-status bit |
| in_mode_o | output | 1 | High while depth is non-zero |
| depth_o | output | $clog2(SAVE_DEPTH+1) | Current nesting depth |
| pend_o | output | 1 | Held-off external request flag |
| take_o | output | 1 | One-cycle pulse when an SMI is taken |
| take_src_o | output | 1 | Source of the SMI taken: 0 internal, 1 external |
| ovf_err_o | output | 1 | One-cycle overflow pulse |
| proto_err_o | output | 1 | One-cycle pulse for a resume at depth 0 |

## Verification
Every result is due one clock edge after the inputs that cause it. This covers the take pulse with its source, the two error pulses, the depth and both bits. A pending external request reaches its take pulse one edge after the cycle in which it first becomes acceptable. The bench changes inputs on the falling edge and compares every output on the next falling edge against a model that it advances once per applied cycle. Directed cases cover the simultaneous-request, overflow, hold-off and depth-0 resume corners, and a seeded random run then mixes all inputs.

// File: rtl/smi_nest_pkg.sv
package smi_nest_pkg;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } smi_src_e;

  typedef struct packed {
    logic     take;
    smi_src_e src;
    logic     resume;
    logic     ovf;
    logic     proto;
    logic     pend_nxt;
  } arb_dec_t;

endpackage

// File: rtl/smi_save_stack.sv
module smi_save_stack #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  localparam int N = 1 << AW;

  logic mem [N];

  // Write-only clocked port with no reset, so the array maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/smi_arbiter.sv
module smi_arbiter
  import smi_nest_pkg::*;
(
  input  logic     depth_zero,
  input  logic     full,
  input  logic     nest_en,
  input  logic     pend,
  input  logic     int_req,
  input  logic     ext_req,
  input  logic     rsm,
  output arb_dec_t dec
);
  logic ext_any;

  always_comb begin
    ext_any      = ext_req | pend;
    dec          = '0;
    dec.src      = SRC_INT;
    dec.proto    = rsm & depth_zero;
    if (rsm && !depth_zero) begin
      // A resume takes priority; any external request waits for a later cycle.
      dec.resume   = 1'b1;
      dec.pend_nxt = ext_any;
    end else if (depth_zero) begin
      if (int_req) begin
        dec.take     = 1'b1;
        dec.src      = SRC_INT;
        dec.pend_nxt = ext_any;
      end else if (ext_any) begin
        dec.take     = 1'b1;
        dec.src      = SRC_EXT;
      end
    end else if (nest_en) begin
      // Inside the mode, internal requests are dropped.
      if (ext_any) begin
        if (full) begin
          dec.ovf  = 1'b1;
        end else begin
          dec.take = 1'b1;
          dec.src  = SRC_EXT;
        end
      end
    end else begin
      dec.pend_nxt = ext_any;
    end
  end

endmodule

// File: rtl/smi_nest_ctrl.sv
module smi_nest_ctrl
  import smi_nest_pkg::*;
#(
  parameter int SAVE_DEPTH = 4,
  localparam int DW = $clog2(SAVE_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          int_req_i,
  input  logic          ext_req_i,
  input  logic          rsm_i,
  input  logic          cfg_we_i,
  input  logic          cfg_wdata_i,
  output logic          nest_en_o,
  output logic          nest_stat_o,
  output logic          in_mode_o,
  output logic [DW-1:0] depth_o,
  output logic          pend_o,
  output logic          take_o,
  output logic          take_src_o,
  output logic          ovf_err_o,
  output logic          proto_err_o
);
  localparam logic [DW-1:0] FULL_D = DW'(SAVE_DEPTH);

  logic [DW-1:0] depth_q, depth_m1;
  logic          nest_en_q, stat_q, pend_q, in_mode_q;
  logic          take_q, ovf_q, proto_q;
  smi_src_e      src_q;
  logic          saved_stat;
  arb_dec_t      dec;

  assign depth_m1 = depth_q - DW'(1);

  smi_arbiter u_arb (
    .depth_zero (depth_q == '0),
    .full       (depth_q == FULL_D),
    .nest_en    (nest_en_q),
    .pend       (pend_q),
    .int_req    (int_req_i),
    .ext_req    (ext_req_i),
    .rsm        (rsm_i),
    .dec        (dec)
  );

  smi_save_stack #(.AW(DW)) u_stack (
    .clk   (clk),
    .we    (dec.take),
    .waddr (depth_q),
    .wdata (stat_q),
    .raddr (depth_m1),
    .rdata (saved_stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q   <= '0;
      nest_en_q <= 1'b1;
      stat_q    <= 1'b0;
      pend_q    <= 1'b0;
      in_mode_q <= 1'b0;
      take_q    <= 1'b0;
      src_q     <= SRC_INT;
      ovf_q     <= 1'b0;
      proto_q   <= 1'b0;
    end else begin
      pend_q  <= dec.pend_nxt;
      take_q  <= dec.take;
      ovf_q   <= dec.ovf;
      proto_q <= dec.proto;
      if (dec.take) src_q <= dec.src;
      if (dec.resume) begin
        nest_en_q <= 1'b1;
        stat_q    <= saved_stat;
        depth_q   <= depth_m1;
        in_mode_q <= (depth_m1 != '0);
      end else if (dec.take) begin
        nest_en_q <= 1'b0;
        stat_q    <= 1'b1;
        depth_q   <= depth_q + DW'(1);
        in_mode_q <= 1'b1;
      end else if (cfg_we_i && depth_q != '0) begin
        nest_en_q <= cfg_wdata_i;
      end
    end
  end

  assign nest_en_o   = nest_en_q;
  assign nest_stat_o = stat_q;
  assign in_mode_o   = in_mode_q;
  assign depth_o     = depth_q;
  assign pend_o      = pend_q;
  assign take_o      = take_q;
  assign take_src_o  = src_q;
  assign ovf_err_o   = ovf_q;
  assign proto_err_o = proto_q;

  // R1: the idle state carries the idle bit values
  a_r1_idle_bits: assert property (@(posedge clk) disable iff (rst)
    (depth_o == '0) |-> (nest_en_o && !nest_stat_o));

  // R2: a take pulse comes with nesting closed and status set
  a_r2_take_state: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (!nest_en_o && nest_stat_o && in_mode_o));

  // R3: depth never exceeds the save stack
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    depth_o <= FULL_D);

  // R4: an external request held off becomes pending, not taken
  a_r4_hold_off: assert property (@(posedge clk) disable iff (rst)
    (in_mode_o && !nest_en_o && ext_req_i && !rsm_i) |=> (pend_o && !take_o));

  // R6: an internal request alone inside the mode is never taken
  a_r6_int_ignored: assert property (@(posedge clk) disable iff (rst)
    (in_mode_o && int_req_i && !ext_req_i && !pend_o) |=> !take_o);

  // R8: resume reopens nesting and pops one level
  a_r8_resume: assert property (@(posedge clk) disable iff (rst)
    (rsm_i && in_mode_o) |=> (nest_en_o && !take_o && depth_o == $past(depth_o) - DW'(1)));

  // R10: resume at depth 0 is flagged and changes nothing
  a_r10_proto: assert property (@(posedge clk) disable iff (rst)
    (rsm_i && depth_o == '0 && !int_req_i && !ext_req_i && !pend_o) |=> (proto_err_o && depth_o == '0));

  // R11: in-mode tracks a non-zero depth
  a_r11_in_mode: assert property (@(posedge clk) disable iff (rst)
    in_mode_o == (depth_o != '0));

endmodule

// File: tb/smi_nest_ctrl_test.sv
`timescale 1ns/1ps
module smi_nest_ctrl_test;
  localparam int N  = 4;
  localparam int DW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic int_req = 0, ext_req = 0, rsm = 0, we = 0, wd = 0;
  logic nest_en, nest_stat, in_mode, pend, take, take_src, ovf, proto;
  logic [DW-1:0] depth;

  int vectors = 0;
  int fails   = 0;

  // Reference state
  bit m_en, m_stat, m_pend, m_take, m_src, m_ovf, m_proto;
  int m_depth;
  bit m_stack [8];

  always #2.5 clk = ~clk;

  smi_nest_ctrl #(.SAVE_DEPTH(N)) uut (
    .clk(clk), .rst(rst), .int_req_i(int_req), .ext_req_i(ext_req),
    .rsm_i(rsm), .cfg_we_i(we), .cfg_wdata_i(wd),
    .nest_en_o(nest_en), .nest_stat_o(nest_stat), .in_mode_o(in_mode),
    .depth_o(depth), .pend_o(pend), .take_o(take), .take_src_o(take_src),
    .ovf_err_o(ovf), .proto_err_o(proto)
  );

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 1; m_stat = 0; m_pend = 0; m_depth = 0;
    m_take = 0; m_src = 0; m_ovf = 0; m_proto = 0;
  endtask

  // Advance the reference by one clock, following the requirements
  function automatic void model_step(bit i, bit e, bit r, bit w, bit d);
    bit any = e | m_pend;
    m_take = 0; m_ovf = 0; m_proto = 0;
    if (r && m_depth > 0) begin
      m_en = 1; m_stat = m_stack[m_depth-1]; m_depth--; m_pend = any;
    end else begin
      m_proto = r;
      if (m_depth == 0) begin
        if (i) begin m_take = 1; m_src = 0; m_pend = any; end
        else if (any) begin m_take = 1; m_src = 1; m_pend = 0; end
        else m_pend = 0;
      end else if (m_en) begin
        if (any) begin
          if (m_depth == N) m_ovf = 1;
          else begin m_take = 1; m_src = 1; end
        end
        m_pend = 0;
      end else m_pend = any;
      if (m_take) begin
        m_stack[m_depth] = m_stat; m_stat = 1; m_en = 0; m_depth++;
      end else if (w && m_depth > 0) m_en = d;
    end
  endfunction

  task automatic compare_all();
    check("R9",  "nest_en",   int'(nest_en),   int'(m_en));
    check("R2",  "nest_stat", int'(nest_stat), int'(m_stat));
    check("R5",  "depth",     int'(depth),     m_depth);
    check("R11", "in_mode",   int'(in_mode),   int'(m_depth != 0));
    check("R4",  "pend",      int'(pend),      int'(m_pend));
    check("R2",  "take",      int'(take),      int'(m_take));
    if (m_take) check("R7", "take_src", int'(take_src), int'(m_src));
    check("R3",  "ovf",       int'(ovf),       int'(m_ovf));
    check("R10", "proto",     int'(proto),     int'(m_proto));
  endtask

  task automatic step(bit i, bit e, bit r, bit w, bit d);
    int_req = i; ext_req = e; rsm = r; we = w; wd = d;
    model_step(i, e, r, w, d);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1", "reset nest_en", int'(nest_en), 1);
    check("R1", "reset stat",    int'(nest_stat), 0);
    check("R1", "reset depth",   int'(depth), 0);
    // R9: write at depth 0 has no effect
    step(0, 0, 0, 1, 0);
    check("R9", "write at depth0 ignored", int'(nest_en), 1);
    // R10: resume at depth 0
    step(0, 0, 1, 0, 0);
    check("R10", "proto pulse", int'(proto), 1);
    // R7: simultaneous requests, internal first, external pending
    step(1, 1, 0, 0, 0);
    check("R7", "internal wins src", int'(take_src), 0);
    check("R7", "external pending", int'(pend), 1);
    // R6: internal ignored inside mode
    step(1, 0, 0, 0, 0);
    check("R6", "internal no take", int'(take), 0);
    // R9 re-arm, then R4 pending serviced as R5 nested level
    step(0, 0, 0, 1, 1);
    check("R9", "re-armed", int'(nest_en), 1);
    step(0, 0, 0, 0, 0);
    check("R4", "pending taken", int'(take), 1);
    check("R5", "depth two", int'(depth), 2);
    // Fill to overflow (R3)
    step(0, 0, 0, 1, 1); step(0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 1); step(0, 1, 0, 0, 0);
    check("R5", "depth full", int'(depth), N);
    step(0, 0, 0, 1, 1); step(0, 1, 0, 0, 0);
    check("R3", "overflow pulse", int'(ovf), 1);
    check("R3", "depth held", int'(depth), N);
    // R8 unwind with restored status, resume beats a request
    step(0, 1, 1, 0, 0);
    check("R8", "restored stat", int'(nest_stat), 1);
    check("R8", "no take on resume", int'(take), 0);
    repeat (3) step(0, 0, 1, 0, 0);
    check("R8", "first level stat", int'(nest_stat), 0);
    check("R1", "idle enable", int'(nest_en), 1);
    // Random mix
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 10) == 0, ($urandom % 5) == 0, ($urandom % 6) == 0,
           ($urandom % 4) == 0, 1'($urandom));
    end
    summary();
    $finish;
  end

endmodule